// File: doc/BRIEF.md
# Flash Operation Busy and Status Controller

This block runs the busy phase of a NOR-style flash program or erase. A command decoder hands it a request: program, sector erase or whole-array erase. For an erase, the block finds which sector holds the request address. The array is split into as many as four consecutive regions, and each region has its own power-of-two sector size. The block then writes all-ones over that sector, or over the whole array, through a byte-wide memory write port.

A prescaled down-counter stands in for the physical operation time. While the operation is in progress, the block produces the polling status byte. Bit 7 carries the inverse of the data's top bit, and bit 6 flips on every host read. After reads return to array data, the block raises a direct-array flag again once the host has made enough consecutive idle reads.

Top module: `flash_op_ctrl`

## Requirements
- R1: A sector erase (req_kind 1) writes exactly the sector that contains req_addr. The regions are laid end to end from address 0 in index order. The sector base is req_addr with its low log2(sector length) bits cleared. Default layout: 4 x 256 B, then 1 x 1024 B, then 1 x 2048 B, giving a 4096-byte array.
- R2: An erase fill drives mem_we for exactly one sector length of consecutive cycles, starting at the base. Each cycle writes mem_wdata = 0xFF, and the address rises by one every cycle. mem_we is never high unless busy is high.
- R3: A chip erase (req_kind 2) fills every address from 0 to 2^ADDR_W-1 with 0xFF.
- R4: busy rises in the cycle after the request is accepted. It stays high for max(TICKS x PRESCALE, N) + 1 cycles, where N is the fill length (0 for program). TICKS is PROG_TICKS, SECT_TICKS or CHIP_TICKS, chosen by the operation.
- R5: While busy is high, a request is ignored. A request with req_kind 3 is always ignored. An ignored request writes no memory, does not restart the timer and does not change status bit 7.
- R6: status_byte bit 7 is set on accept. For a program (req_kind 0) it becomes the inverse of req_bit7. For either erase it becomes 0. It then holds until the next accepted request.
- R7: status_byte bit 6 inverts after every cycle in which rd_en is high while busy is high. Reads while idle leave it unchanged. Bits 5..0 are always 0.
- R8: array_direct goes low in the cycle after any accepted request. It returns high after LAZY_READS+1 (default 43) idle reads. A read counts only when rd_en is high, busy is low and seq_idle is high. A cycle with seq_idle low restarts the count.
- R9: After reset, busy, mem_we and status_byte are 0 and array_direct is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request strobe from the command decoder |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| req_addr | input | ADDR_W | Byte address of the request |
| req_bit7 | input | 1 | Bit 7 of the data being programmed |
| rd_en | input | 1 | Host read strobe |
| seq_idle | input | 1 | High when no command sequence is in progress |
| busy | output | 1 | Operation in progress; reads return status |
| status_byte | output | 8 | Polling status byte |
| array_direct | output | 1 | Reads may go straight to the array |
| mem_we | output | 1 | Memory write enable of the fill port |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
On every cycle, the assertions check the following. The fill address climbs by one on each back-to-back write. Writes happen only inside the busy window. busy cannot fall while the timer is still running. Status bit 6 flips on a busy read, and ignored requests leave bit 7 alone. Only the bench scenarios can show the rest: that the erased range matches the arithmetic sector of each swept address, that the busy length equals the larger of the timer and fill times, that the array outside the sector keeps its contents, and the exact read count at which direct array mode returns.

// File: rtl/flash_pkg.sv
package flash_pkg;
    localparam int unsigned MAX_REGIONS = 4;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_CHIP  = 2'd2,
        OP_NONE  = 2'd3
    } flash_op_e;
endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
    import flash_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned REG_BLOCKS [MAX_REGIONS] = '{4, 1, 1, 0},
    parameter int unsigned REG_SECT_LOG2 [MAX_REGIONS] = '{8, 10, 11, 8}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W:0]   len
);
    localparam int unsigned LW = ADDR_W + 1;

    // byte offset at which region k begins
    function automatic longint unsigned region_lo(int unsigned k);
        longint unsigned acc = 0;
        for (int unsigned i = 0; i < k; i++) begin
            acc += longint'(REG_BLOCKS[i]) << REG_SECT_LOG2[i];
        end
        return acc;
    endfunction

    logic [MAX_REGIONS-1:0] hit_v;
    logic [LW-1:0]          len_v [MAX_REGIONS];

    for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_region
        localparam longint unsigned LO = region_lo(g);
        localparam longint unsigned HI = region_lo(g + 1);
        assign hit_v[g] = (REG_BLOCKS[g] != 0)
                       && ({1'b0, addr} >= LW'(LO))
                       && ({1'b0, addr} <  LW'(HI));
        assign len_v[g] = LW'(longint'(1) << REG_SECT_LOG2[g]);
    end

    always_comb begin
        logic found;
        logic [LW-1:0] mask;
        found = 1'b0;
        len   = len_v[0];
        for (int i = 0; i < MAX_REGIONS; i++) begin
            if (!found && hit_v[i]) begin
                found = 1'b1;
                len   = len_v[i];
            end
        end
        mask = len - LW'(1);
        base = addr & ~mask[ADDR_W-1:0];
    end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int unsigned PRESCALE = 4,
    parameter int unsigned TICK_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TICK_W-1:0] ticks,
    output logic              zero
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [TICK_W-1:0] cnt;
        logic [PRE_W-1:0]  pre;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.cnt = ticks;
            nxt_d.pre = PRE_W'(PRESCALE - 1);
        end else if (cur_q.cnt != '0) begin
            if (cur_q.pre == '0) begin
                nxt_d.cnt = cur_q.cnt - TICK_W'(1);
                nxt_d.pre = PRE_W'(PRESCALE - 1);
            end else begin
                nxt_d.pre = cur_q.pre - PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign zero = (cur_q.cnt == '0);

    // R4: without a reload the count never rises
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cur_q.cnt != '0) |=> (cur_q.cnt <= $past(cur_q.cnt)));
endmodule

// File: rtl/flash_fill_seq.sv
module flash_fill_seq #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W:0]   len,
    output logic              active,
    output logic              we,
    output logic [ADDR_W-1:0] waddr
);
    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W:0]   left;
    } fill_t;

    fill_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (start) begin
            nxt_d.active = (len != '0);
            nxt_d.addr   = base;
            nxt_d.left   = len;
        end else if (cur_q.active) begin
            nxt_d.addr = cur_q.addr + ADDR_W'(1);
            nxt_d.left = cur_q.left - (ADDR_W+1)'(1);
            if (cur_q.left == (ADDR_W+1)'(1)) nxt_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign active = cur_q.active;
    assign we     = cur_q.active;
    assign waddr  = cur_q.addr;

    // R2: back-to-back writes walk upward one byte at a time
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $past(we) && !$past(start)) |-> (waddr == $past(waddr) + ADDR_W'(1)));
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import flash_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned REG_BLOCKS [MAX_REGIONS] = '{4, 1, 1, 0},
    parameter int unsigned REG_SECT_LOG2 [MAX_REGIONS] = '{8, 10, 11, 8},
    parameter int unsigned PRESCALE   = 4,
    parameter int unsigned PROG_TICKS = 3,
    parameter int unsigned SECT_TICKS = 300,
    parameter int unsigned CHIP_TICKS = 1500,
    parameter int unsigned LAZY_READS = 42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_bit7,
    input  logic              rd_en,
    input  logic              seq_idle,
    output logic              busy,
    output logic [7:0]        status_byte,
    output logic              array_direct,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    localparam int unsigned TICK_W = $clog2(max3(PROG_TICKS, SECT_TICKS, CHIP_TICKS) + 1);
    localparam int unsigned LAZY_W = $clog2(LAZY_READS + 1);

    typedef struct packed {
        logic              busy;
        logic              dq7;
        logic              dq6;
        logic              direct;
        logic [LAZY_W-1:0] lazy;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic              accept;
    logic              is_erase;
    logic              fill_active;
    logic              tmr_zero;
    logic [TICK_W-1:0] ticks_sel;
    logic [ADDR_W-1:0] sect_base;
    logic [ADDR_W:0]   sect_len;
    logic [ADDR_W-1:0] fill_base;
    logic [ADDR_W:0]   fill_len;

    flash_sector_map #(
        .ADDR_W        (ADDR_W),
        .REG_BLOCKS    (REG_BLOCKS),
        .REG_SECT_LOG2 (REG_SECT_LOG2)
    ) u_map (
        .addr (req_addr),
        .base (sect_base),
        .len  (sect_len)
    );

    assign accept   = req_valid && !cur_q.busy && (req_kind != OP_NONE);
    assign is_erase = (req_kind == OP_SECT) || (req_kind == OP_CHIP);

    always_comb begin
        if (req_kind == OP_CHIP) begin
            fill_base = '0;
            fill_len  = (ADDR_W+1)'(1) << ADDR_W;
            ticks_sel = TICK_W'(CHIP_TICKS);
        end else if (req_kind == OP_SECT) begin
            fill_base = sect_base;
            fill_len  = sect_len;
            ticks_sel = TICK_W'(SECT_TICKS);
        end else begin
            fill_base = sect_base;
            fill_len  = sect_len;
            ticks_sel = TICK_W'(PROG_TICKS);
        end
    end

    flash_fill_seq #(
        .ADDR_W (ADDR_W)
    ) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept && is_erase),
        .base   (fill_base),
        .len    (fill_len),
        .active (fill_active),
        .we     (mem_we),
        .waddr  (mem_addr)
    );

    flash_busy_timer #(
        .PRESCALE (PRESCALE),
        .TICK_W   (TICK_W)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .ticks (ticks_sel),
        .zero  (tmr_zero)
    );

    always_comb begin
        nxt_d = cur_q;
        if (accept) begin
            nxt_d.busy   = 1'b1;
            nxt_d.direct = 1'b0;
            nxt_d.lazy   = '0;
            nxt_d.dq7    = (req_kind == OP_PROG) ? ~req_bit7 : 1'b0;
        end else if (cur_q.busy && !fill_active && tmr_zero) begin
            nxt_d.busy = 1'b0;
        end

        if (cur_q.busy && rd_en) nxt_d.dq6 = ~cur_q.dq6;

        if (!seq_idle) begin
            nxt_d.lazy = '0;
        end else if (!accept && rd_en && !cur_q.busy && !cur_q.direct) begin
            if (cur_q.lazy == LAZY_W'(LAZY_READS)) nxt_d.direct = 1'b1;
            else                                   nxt_d.lazy   = cur_q.lazy + LAZY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= '0;
            cur_q.direct <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy         = cur_q.busy;
    assign status_byte  = {cur_q.dq7, cur_q.dq6, 6'b0};
    assign array_direct = cur_q.direct;
    assign mem_wdata    = 8'hFF;

    // R2: fill writes happen only inside the busy window
    p_we_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R4: busy may not drop while the timer is still counting
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_zero) |=> busy);

    // R5: a request arriving while busy leaves status bit 7 alone
    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(status_byte[7]));

    // R7: a read during the operation flips status bit 6
    p_dq6_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> (status_byte[6] != $past(status_byte[6])));

    // R8: an accepted request leaves direct array mode
    p_direct_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_kind != OP_NONE) |=> !array_direct);
endmodule

// File: tb/flash_op_ctrl_bench.sv
module flash_op_ctrl_bench;
    localparam int AW    = 12;
    localparam int SIZE  = 1 << AW;
    localparam int PRE   = 4;
    localparam int T_PRG = 3;
    localparam int T_SEC = 300;
    localparam int T_CHP = 1500;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic          req_bit7 = 1'b0;
    logic          rd_en = 1'b0;
    logic          seq_idle = 1'b1;
    logic          busy;
    logic [7:0]    status_byte;
    logic          array_direct;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int we_total = 0;
    logic [7:0] mem [SIZE];
    logic [7:0] expm [SIZE];

    always #10 clk = ~clk;

    flash_op_ctrl u_flash_op_ctrl (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
        .req_addr (req_addr), .req_bit7 (req_bit7), .rd_en (rd_en),
        .seq_idle (seq_idle), .busy (busy), .status_byte (status_byte),
        .array_direct (array_direct), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic int sec_len(int a);
        if (a < 1024) return 256;
        if (a < 2048) return 1024;
        return 2048;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < SIZE; i++) mem[i] = pat(i);
        end else if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            we_total++;
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic issue(logic [1:0] kind, int addr, logic b7);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = AW'(addr);
        req_bit7  = b7;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // counts busy samples from the current negedge; optionally pokes a stray request
    task automatic wait_idle(bit poke, output int n);
        n = 0;
        while (busy) begin
            n++;
            if (poke && n == 5) begin
                req_valid = 1'b1;
                req_kind  = 2'd2;
                req_addr  = '0;
                req_bit7  = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            if (n > 20000) break;
        end
        req_valid = 1'b0;
    endtask

    function automatic int mismatches();
        int m = 0;
        for (int i = 0; i < SIZE; i++) if (mem[i] !== expm[i]) m++;
        return m;
    endfunction

    task automatic sector_erase(int a, bit poke);
        int n, w0, len, base, exp_n, bad;
        len   = sec_len(a);
        base  = a - (a % len);
        w0    = we_total;
        issue(2'd1, a, 1'b0);
        chk(status_byte[7] == 1'b0, "R6 erase dq7", status_byte[7], 0);
        wait_idle(poke, n);
        exp_n = (T_SEC * PRE > len ? T_SEC * PRE : len) + 1;
        chk(n == exp_n, poke ? "R5 busy length with stray request" : "R4 sector busy length", n, exp_n);
        chk(we_total - w0 == len, "R2 fill write count", we_total - w0, len);
        for (int i = base; i < base + len; i++) expm[i] = 8'hFF;
        bad = mismatches();
        chk(bad == 0, poke ? "R5 array after stray request" : "R1 erased range", bad, 0);
    endtask

    initial begin
        int n, w0, bad;
        logic [7:0] st;
        for (int i = 0; i < SIZE; i++) expm[i] = pat(i);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mem_we == 1'b0, "R9 reset busy/we", {busy, mem_we}, 0);
        chk(status_byte == 8'h00, "R9 reset status", status_byte, 0);
        chk(array_direct == 1'b1, "R9 reset direct", array_direct, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: kind 3 is never accepted
        w0 = we_total;
        req_valid = 1'b1; req_kind = 2'd3; req_addr = 12'd40;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && we_total == w0, "R5 kind 3 ignored", busy, 0);
        chk(array_direct == 1'b1, "R5 kind 3 keeps direct", array_direct, 1);

        // R6 / R7 on a program operation
        issue(2'd0, 100, 1'b1);
        chk(busy == 1'b1, "R4 busy after accept", busy, 1);
        chk(status_byte[7] == 1'b0, "R6 program dq7 inverse of 1", status_byte[7], 0);
        chk(status_byte[5:0] == 6'd0, "R7 low status bits", status_byte[5:0], 0);
        chk(array_direct == 1'b0, "R8 direct drops on accept", array_direct, 0);
        st = status_byte;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(status_byte[6] == ~st[6], "R7 dq6 flips on busy read", status_byte[6], ~st[6]);
        wait_idle(1'b0, n);
        chk(n + 1 == T_PRG * PRE + 1, "R4 program busy length", n + 1, T_PRG * PRE + 1);
        st = status_byte;
        seq_idle = 1'b0;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        seq_idle = 1'b1;
        @(negedge clk);
        chk(status_byte[6] == st[6], "R7 idle read keeps dq6", status_byte[6], st[6]);

        issue(2'd0, 7, 1'b0);
        chk(status_byte[7] == 1'b1, "R6 program dq7 inverse of 0", status_byte[7], 1);
        wait_idle(1'b0, n);

        // R8: lazy return, with a restart in the middle
        rd_en = 1'b1;
        repeat (30) @(negedge clk);
        rd_en = 1'b0;
        seq_idle = 1'b0;
        @(negedge clk);
        seq_idle = 1'b1;
        rd_en = 1'b1;
        repeat (42) @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk(array_direct == 1'b0, "R8 still indirect after 42 reads", array_direct, 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(array_direct == 1'b1, "R8 direct after 43rd read", array_direct, 1);

        // R1 / R2 / R4: sweep of sector erases across all regions
        for (int k = 0; k < 12; k++) sector_erase((k * 389 + 17) % SIZE, 1'b0);

        // R5: stray chip erase during a sector erase (region 0 sector not yet touched above)
        for (int i = 512; i < 768; i++) begin
            expm[i] = 8'h00;
        end
        sector_erase(600, 1'b1);

        // R3: chip erase
        w0 = we_total;
        issue(2'd2, 1234, 1'b0);
        wait_idle(1'b0, n);
        chk(n == T_CHP * PRE + 1, "R4 chip busy length", n, T_CHP * PRE + 1);
        chk(we_total - w0 == SIZE, "R3 chip write count", we_total - w0, SIZE);
        bad = 0;
        for (int i = 0; i < SIZE; i++) if (mem[i] !== 8'hFF) bad++;
        chk(bad == 0, "R3 whole array erased", bad, 0);
        chk(mem_we == 1'b0, "R2 no writes when idle", mem_we, 0);

        finish_run();
    end
endmodule